// File: doc/BRIEF.md
# Compare Flags and Condition Evaluator

This unit holds the four condition flags of a 32-bit processor core: negative (N), zero (Z), carry (C) and overflow (V). A compare strobe loads these flags from one of two sources. The first is an integer subtraction of two operands. The second is the four one-hot result bits of an external floating-point comparator (less, equal, greater, unordered). Each flag has its own validity bit, so a flag with no defined value is carried as invalid. It is not given an arbitrary value.

A combinational evaluator reads the stored flags and a four-bit condition selector. It reports whether the condition holds and whether that answer is defined. The result drives two consumers in the same cycle:

- A conditional branch: take the target, fall through, or raise a fault.
- A conditional move: write the source, keep the old destination, or mark the destination as undefined.

Instruction decode, the floating-point comparator and the register file are outside this unit.

Top module: `cmpflag_unit`

## Requirements
- R1: An integer compare (cmp_en=1, cmp_is_fp=0) of op_a and op_b sets N to bit 31 of op_a−op_b, Z to (op_a==op_b), C to unsigned op_a≥op_b, and V to signed overflow of op_a−op_b. All four flags become valid. flag_val bit order is {N,Z,C,V}, with N in bit 3, and flag_ok uses the same order.
- R2: A float compare with fp_ops_ok=1 and exactly one result bit set loads these flags as {N,Z,C,V}: less gives 1000, equal gives 0110, greater gives 0010, unordered gives 0011. All four flags become valid.
- R3: A float compare with fp_ops_ok=0 clears all four flag valid bits.
- R4: Codes 0 to 11 of cond_sel select, in order, EQ=Z, NE=!Z, HS=C, LO=!C, MI=N, PL=!N, HI=C&!Z, LS=!C|Z, GE=(N==V), LT=(N!=V), GT=(N==V)&!Z, LE=(N!=V)|Z. The result appears on cond_true when cond_defined=1.
- R5: Codes 12 to 15 are reserved. They give cond_defined=0 and cond_true=0.
- R6: A condition whose flags include any invalid flag gives cond_defined=0 and cond_true=0. Flags the condition does not read have no effect on it.
- R7: With br_req=1, a true condition raises br_take, a false condition raises br_fall, and an undefined condition raises br_fault. Exactly one of the three is high. All three are low when br_req=0.
- R8: With mov_req=1, a true condition gives mov_wdata=mov_src and mov_wok=1. A false condition gives mov_wdata=mov_dst and mov_wok=mov_dst_ok. An undefined condition gives mov_wdata=mov_dst and mov_wok=0. With mov_req=0 the old destination passes through unchanged.
- R9: With cmp_en=0 the flags and their valid bits hold their values, whatever is on the operand inputs.
- R10: Reset, which is asynchronous and active low, clears all flag values and valid bits.
- R11: Flags loaded at a clock edge are seen by the condition outputs immediately after that edge, with no added delay.
- R12: A float compare with fp_ops_ok=1 whose four result bits are not exactly one-hot clears all flag valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Load the flags at this edge |
| cmp_is_fp | input | 1 | 1 selects the float result bits, 0 selects the integer operands |
| op_a | input | W | Integer compare left operand |
| op_b | input | W | Integer compare right operand |
| fp_lt | input | 1 | Float comparator: less |
| fp_eq | input | 1 | Float comparator: equal |
| fp_gt | input | 1 | Float comparator: greater |
| fp_un | input | 1 | Float comparator: unordered |
| fp_ops_ok | input | 1 | Both float operands were valid floats |
| cond_sel | input | 4 | Condition code |
| br_req | input | 1 | Conditional branch in progress |
| mov_req | input | 1 | Conditional move in progress |
| mov_src | input | W | Move source value |
| mov_dst | input | W | Current destination value |
| mov_dst_ok | input | 1 | Current destination is defined |
| flag_val | output | 4 | Stored flags {N,Z,C,V} |
| flag_ok | output | 4 | Per-flag validity {N,Z,C,V} |
| cond_true | output | 1 | Selected condition holds |
| cond_defined | output | 1 | Selected condition is defined |
| br_take | output | 1 | Branch to the target |
| br_fall | output | 1 | Fall through |
| br_fault | output | 1 | Branch on an undefined condition |
| mov_wdata | output | W | Destination write value |
| mov_wok | output | 1 | Destination defined after the move |

## Verification
A compare presented before a rising edge updates flag_val and flag_ok at that edge. The branch and move outputs then follow combinationally within the same cycle, from the new flags and the cond_sel that is still held. The bench drives each vector at the falling edge and queues its expected outcome. The monitor checks every output 2 ns after the next rising edge, which is exactly one register stage after the stimulus. Vectors with cmp_en low are checked at the same point, so the held flags are compared against the operands that were ignored.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  // Flag positions inside the 4-bit flag vector {N,Z,C,V}
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  localparam int NUM_COND = 12;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_HI = 4'd6,  CC_LS = 4'd7,
    CC_GE = 4'd8,  CC_LT = 4'd9,  CC_GT = 4'd10, CC_LE = 4'd11
  } cond_code_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/cmpflag_int_calc.sv
module cmpflag_int_calc
  import cmpflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output flags_t       flags
);
  localparam int MSB = W - 1;

  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, a} - {1'b0, b};
    flags.n = diff[MSB];
    flags.z = (a == b);
    flags.c = ~diff[W];
    flags.v = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
  end
endmodule

// File: rtl/cmpflag_fp_encode.sv
module cmpflag_fp_encode
  import cmpflag_pkg::*;
(
  input  logic   lt,
  input  logic   eq,
  input  logic   gt,
  input  logic   un,
  input  logic   ops_ok,
  output flags_t flags,
  output logic   all_ok
);
  logic [2:0] hot_cnt;

  always_comb begin
    hot_cnt = {2'b00, lt} + {2'b00, eq} + {2'b00, gt} + {2'b00, un};
    all_ok  = ops_ok && (hot_cnt == 3'd1);
    flags.n = lt;
    flags.z = eq;
    flags.c = ~lt;
    flags.v = un;
    if (!all_ok) flags = '0;
  end
endmodule

// File: rtl/cmpflag_cond_eval.sv
module cmpflag_cond_eval
  import cmpflag_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] flags_ok,
  input  logic [3:0] sel,
  output logic       holds,
  output logic       defined
);
  logic [3:0] need;
  logic       raw;
  logic       known_code;
  logic       nv_ne;

  always_comb begin
    nv_ne      = flags.n ^ flags.v;
    known_code = (sel < 4'(NUM_COND));
    need       = 4'b0000;
    raw        = 1'b0;
    case (sel)
      CC_EQ: begin raw = flags.z;               need[FL_Z] = 1'b1; end
      CC_NE: begin raw = ~flags.z;              need[FL_Z] = 1'b1; end
      CC_HS: begin raw = flags.c;               need[FL_C] = 1'b1; end
      CC_LO: begin raw = ~flags.c;              need[FL_C] = 1'b1; end
      CC_MI: begin raw = flags.n;               need[FL_N] = 1'b1; end
      CC_PL: begin raw = ~flags.n;              need[FL_N] = 1'b1; end
      CC_HI: begin raw = flags.c & ~flags.z;    need[FL_C] = 1'b1; need[FL_Z] = 1'b1; end
      CC_LS: begin raw = ~flags.c | flags.z;    need[FL_C] = 1'b1; need[FL_Z] = 1'b1; end
      CC_GE: begin raw = ~nv_ne;                need[FL_N] = 1'b1; need[FL_V] = 1'b1; end
      CC_LT: begin raw = nv_ne;                 need[FL_N] = 1'b1; need[FL_V] = 1'b1; end
      CC_GT: begin raw = ~nv_ne & ~flags.z;     need = 4'b1101; end
      CC_LE: begin raw = nv_ne | flags.z;       need = 4'b1101; end
      default: begin raw = 1'b0;                need = 4'b0000; end
    endcase
    defined = known_code && ((flags_ok & need) == need);
    holds   = defined && raw;
  end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  logic         cmp_is_fp,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         fp_lt,
  input  logic         fp_eq,
  input  logic         fp_gt,
  input  logic         fp_un,
  input  logic         fp_ops_ok,
  input  logic [3:0]   cond_sel,
  input  logic         br_req,
  input  logic         mov_req,
  input  logic [W-1:0] mov_src,
  input  logic [W-1:0] mov_dst,
  input  logic         mov_dst_ok,
  output logic [3:0]   flag_val,
  output logic [3:0]   flag_ok,
  output logic         cond_true,
  output logic         cond_defined,
  output logic         br_take,
  output logic         br_fall,
  output logic         br_fault,
  output logic [W-1:0] mov_wdata,
  output logic         mov_wok
);
  flags_t     int_flags, fp_flags;
  logic       fp_all_ok;
  flags_t     flags_q, flags_d;
  logic [3:0] ok_q, ok_d;

  cmpflag_int_calc #(.W(W)) int_calc_i (
    .a     (op_a),
    .b     (op_b),
    .flags (int_flags)
  );

  cmpflag_fp_encode fp_enc_i (
    .lt     (fp_lt),
    .eq     (fp_eq),
    .gt     (fp_gt),
    .un     (fp_un),
    .ops_ok (fp_ops_ok),
    .flags  (fp_flags),
    .all_ok (fp_all_ok)
  );

  // Next-state selection
  always_comb begin
    flags_d = flags_q;
    ok_d    = ok_q;
    if (cmp_en) begin
      if (cmp_is_fp) begin
        flags_d = fp_flags;
        ok_d    = {4{fp_all_ok}};
      end else begin
        flags_d = int_flags;
        ok_d    = 4'hF;
      end
    end
  end

  // Flag register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ok_q    <= '0;
    end else begin
      flags_q <= flags_d;
      ok_q    <= ok_d;
    end
  end

  cmpflag_cond_eval cond_i (
    .flags    (flags_q),
    .flags_ok (ok_q),
    .sel      (cond_sel),
    .holds    (cond_true),
    .defined  (cond_defined)
  );

  // Consumers
  always_comb begin
    br_take  = br_req &  cond_defined &  cond_true;
    br_fall  = br_req &  cond_defined & ~cond_true;
    br_fault = br_req & ~cond_defined;

    mov_wdata = mov_dst;
    mov_wok   = mov_dst_ok;
    if (mov_req) begin
      if (!cond_defined) begin
        mov_wok = 1'b0;
      end else if (cond_true) begin
        mov_wdata = mov_src;
        mov_wok   = 1'b1;
      end
    end
  end

  assign flag_val = flags_q;
  assign flag_ok  = ok_q;
endmodule

// File: rtl/cmpflag_unit_chk.sv
module cmpflag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmp_en,
  input logic         cmp_is_fp,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         fp_ops_ok,
  input logic [3:0]   cond_sel,
  input logic         br_req,
  input logic         mov_req,
  input logic [3:0]   flag_val,
  input logic [3:0]   flag_ok,
  input logic         cond_defined,
  input logic         br_take,
  input logic         br_fault,
  input logic         mov_wok
);
  // R1
  int_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !cmp_is_fp) |=> (flag_ok == 4'hF) && (flag_val[2] == ($past(op_a) == $past(op_b))));

  // R3
  fp_bad_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_is_fp && !fp_ops_ok) |=> (flag_ok == 4'h0));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel >= 4'd12) |-> !cond_defined);

  // R7
  br_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !cond_defined) |-> (br_fault && !br_take));

  // R8
  mov_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_req && !cond_defined) |-> !mov_wok);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(flag_val) && $stable(flag_ok)));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (flag_ok == 4'h0);
    end
  end
endmodule

bind cmpflag_unit cmpflag_unit_chk #(.W(W)) chk_i (.*);

// File: tb/cmpflag_unit_tb_top.sv
module cmpflag_unit_tb_top;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         cmp_en, cmp_is_fp;
  logic [W-1:0] op_a, op_b;
  logic         fp_lt, fp_eq, fp_gt, fp_un, fp_ops_ok;
  logic [3:0]   cond_sel;
  logic         br_req, mov_req;
  logic [W-1:0] mov_src, mov_dst;
  logic         mov_dst_ok;
  logic [3:0]   flag_val, flag_ok;
  logic         cond_true, cond_defined;
  logic         br_take, br_fall, br_fault;
  logic [W-1:0] mov_wdata;
  logic         mov_wok;

  cmpflag_unit #(.W(W)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [3:0]   fv;
    logic [3:0]   fo;
    logic         ct, cd, bt, bf, bx;
    logic [W-1:0] md;
    logic         mo;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  // bench flag model {N,Z,C,V}
  logic [3:0] m_fv = 4'h0;
  logic [3:0] m_fo = 4'h0;

  function automatic logic [3:0] model_int(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] d;
    logic n, z, c, v, slt;
    d   = a - b;
    n   = d[W-1];
    z   = (a == b);
    c   = (a >= b);
    slt = ($signed(a) < $signed(b));
    v   = n ^ slt;
    return {n, z, c, v};
  endfunction

  // returns {defined, holds}
  function automatic logic [1:0] model_cond(logic [3:0] fv, logic [3:0] fo, logic [3:0] s);
    logic n, z, c, v, r, d;
    {n, z, c, v} = fv;
    d = 1'b0; r = 1'b0;
    case (s)
      4'd0:  begin r = z;                 d = fo[2]; end
      4'd1:  begin r = !z;                d = fo[2]; end
      4'd2:  begin r = c;                 d = fo[1]; end
      4'd3:  begin r = !c;                d = fo[1]; end
      4'd4:  begin r = n;                 d = fo[3]; end
      4'd5:  begin r = !n;                d = fo[3]; end
      4'd6:  begin r = c && !z;           d = fo[1] && fo[2]; end
      4'd7:  begin r = !c || z;           d = fo[1] && fo[2]; end
      4'd8:  begin r = (n == v);          d = fo[3] && fo[0]; end
      4'd9:  begin r = (n != v);          d = fo[3] && fo[0]; end
      4'd10: begin r = (n == v) && !z;    d = fo[3] && fo[0] && fo[2]; end
      4'd11: begin r = (n != v) || z;     d = fo[3] && fo[0] && fo[2]; end
      default: begin r = 1'b0;            d = 1'b0; end
    endcase
    return {d, d && r};
  endfunction

  task automatic drive(input logic en, input logic isfp, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [3:0] fpbits, input logic fpok,
                       input logic [3:0] sel, input logic br, input logic mv,
                       input logic [W-1:0] src, input logic [W-1:0] dst,
                       input logic dok, input string tag);
    exp_t e;
    logic [1:0] cr;
    @(negedge clk);
    cmp_en = en; cmp_is_fp = isfp; op_a = a; op_b = b;
    {fp_lt, fp_eq, fp_gt, fp_un} = fpbits; fp_ops_ok = fpok;
    cond_sel = sel; br_req = br; mov_req = mv;
    mov_src = src; mov_dst = dst; mov_dst_ok = dok;
    if (en) begin
      if (!isfp) begin
        m_fv = model_int(a, b); m_fo = 4'hF;
      end else if (fpok && $countones(fpbits) == 1) begin
        m_fo = 4'hF;
        case (fpbits)
          4'b1000: m_fv = 4'b1000;
          4'b0100: m_fv = 4'b0110;
          4'b0010: m_fv = 4'b0010;
          default: m_fv = 4'b0011;
        endcase
      end else begin
        m_fv = 4'h0; m_fo = 4'h0;
      end
    end
    cr   = model_cond(m_fv, m_fo, sel);
    e.fv = m_fv; e.fo = m_fo;
    e.cd = cr[1]; e.ct = cr[0];
    e.bt = br && cr[1] && cr[0];
    e.bf = br && cr[1] && !cr[0];
    e.bx = br && !cr[1];
    if (mv && cr[1] && cr[0]) begin e.md = src; e.mo = 1'b1; end
    else if (mv && !cr[1])    begin e.md = dst; e.mo = 1'b0; end
    else                      begin e.md = dst; e.mo = dok;  end
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one register stage after each drive
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_checks++;
      if ({flag_val, flag_ok, cond_true, cond_defined, br_take, br_fall, br_fault, mov_wdata, mov_wok} !==
          {e.fv, e.fo, e.ct, e.cd, e.bt, e.bf, e.bx, e.md, e.mo}) begin
        n_fail++;
        $display("FAIL %s sel=%0d: act fv=%b fo=%b ct=%b cd=%b br=%b%b%b md=%h mo=%b exp fv=%b fo=%b ct=%b cd=%b br=%b%b%b md=%h mo=%b",
                 e.tag, cond_sel, flag_val, flag_ok, cond_true, cond_defined, br_take, br_fall, br_fault,
                 mov_wdata, mov_wok, e.fv, e.fo, e.ct, e.cd, e.bt, e.bf, e.bx, e.md, e.mo);
      end
    end
  end

  task automatic direct_check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) begin
      drive(1'b0, 1'b0, 32'hDEAD_0000 + s, 32'h0000_BEEF, 4'b0000, 1'b0, 4'(s), 1'b1, 1'b1,
            32'hA5A5_0000 + s, 32'h5A5A_0000 + s, s[0], tag);
    end
  endtask

  task automatic int_cmp(input logic [W-1:0] a, input logic [W-1:0] b);
    // R1 R11: compare and evaluate in the cycle right after
    drive(1'b1, 1'b0, a, b, 4'b0000, 1'b0, 4'd0, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222, 1'b1, "R1_R11");
    sweep("R4_R5_R7_R8_R9");
  endtask

  task automatic fp_cmp(input logic [3:0] bits, input logic ok, input string tag);
    drive(1'b1, 1'b1, 32'h0, 32'h0, bits, ok, 4'd10, 1'b1, 1'b1, 32'h3333_3333, 32'h4444_4444, 1'b1, tag);
    sweep(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    cmp_en = 0; cmp_is_fp = 0; op_a = '0; op_b = '0;
    fp_lt = 0; fp_eq = 0; fp_gt = 0; fp_un = 0; fp_ops_ok = 0;
    cond_sel = 4'd0; br_req = 1'b1; mov_req = 1'b0;
    mov_src = '0; mov_dst = '0; mov_dst_ok = 1'b0;
    #3;
    // R10: reset state
    direct_check(flag_ok == 4'h0 && flag_val == 4'h0, "R10 reset flags", {flag_val, flag_ok}, 8'h00);
    direct_check(!cond_defined && br_fault && !br_take, "R6 R7 reset fault", {5'b0, cond_defined, br_fault, br_take}, 8'h02);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    int_cmp(32'd5, 32'd5);
    int_cmp(32'd3, 32'd7);
    int_cmp(32'd7, 32'd3);
    int_cmp(32'h8000_0000, 32'd1);
    int_cmp(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    int_cmp(32'd0, 32'hFFFF_FFFF);

    fp_cmp(4'b1000, 1'b1, "R2 less");
    fp_cmp(4'b0100, 1'b1, "R2 equal");
    fp_cmp(4'b0010, 1'b1, "R2 greater");
    fp_cmp(4'b0001, 1'b1, "R2 unordered");
    fp_cmp(4'b0100, 1'b0, "R3 R6 bad operands");
    int_cmp(32'd9, 32'd2);
    fp_cmp(4'b0110, 1'b1, "R12 not one-hot");
    fp_cmp(4'b0000, 1'b1, "R12 none set");

    // R7 R8: idle requests give no branch action and pass-through move
    int_cmp(32'd1, 32'd1);
    drive(1'b0, 1'b0, 32'd0, 32'd0, 4'b0, 1'b0, 4'd0, 1'b0, 1'b0, 32'hCAFE_0001, 32'hCAFE_0002, 1'b0, "R7_R8 idle");

    // R10: reset mid-run clears valid flags
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    direct_check(flag_ok == 4'h0, "R10 mid-run reset", {4'h0, flag_ok}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    m_fv = 4'h0; m_fo = 4'h0;
    sweep("R10_R6 after reset");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule